// File: doc/BRIEF.md
# Gated SD Card Clock Divider

This block derives the card-side SD clock from the controller's base clock. Software writes one control word. A one-hot select byte picks a power-of-two ratio. Two override bits pick pass-through (/1) or an extended /1024. An enable bit gates the card clock on and off. An auto-stop bit lets the data path park the clock whenever it reports the bus as idle.

Changes to the ratio never produce a runt pulse. A new ratio or mode is taken over only while the output is low and gated off. When the clock is stopped, the high half it has started always runs to completion, and the output then rests low. Software is expected to clear the enable bit, write the new ratio and set the enable bit again. The extended /1024 ratio exists only when the `EXT_DIV1024` parameter is set.

The ratio field, the enable and auto-stop bits, and the two override bits all sit in one control word. The write strobe loads the whole word in one cycle.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the enable bit (bit 8) is clear and sd_clk stays low until a write sets it.
- R2: With bits [7:0], bit 10 and bit 16 all clear, the card clock is the base clock divided by 2.
- R3: With bit i of [7:0] set (i = 0..7), the ratio is 2^(i+2): bit 0 gives /4 and bit 7 gives /512. In divided modes, for half period H the output is low for the first H-1 base cycles after the enabling write, rises on cycle H, and then toggles every H cycles.
- R4: Bit 10 selects /1. While enabled, sd_clk follows the base clock, and any gate change happens while the base clock is low.
- R5: Bit 16 selects /1024 when EXT_DIV1024 is 1. When EXT_DIV1024 is 0, the bit is ignored and the one-hot byte decides the ratio.
- R6: When several select bits are set, the priority is bit 10 (/1), then bit 16 (/1024, extended only), then the highest set bit of [7:0].
- R7: Clearing the enable bit lets a started high half finish. sd_clk then stays low for as long as the clock is stopped.
- R8: A ratio or mode written while the clock runs has no effect. The active setting is reloaded only while the clock is stopped with the output low, and the half-period counter then restarts from zero.
- R9: With the auto-stop bit (bit 9) set, the clock stops as in R7 from the first low phase after bus_busy falls. It resumes when bus_busy rises, and its first rising edge comes H base cycles after that.
- R10: A divided output changes only when the half-period counter reaches its terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W | Control word |
| bus_busy | input | 1 | Data path busy; low means idle |
| sd_clk | output | 1 | Gated, divided card clock |

## Verification
A control write is captured on the edge that samples the strobe, and the clock starts running right after that edge. In divided modes, the level after the k-th following edge is expected to be floor(k/H) mod 2. In pass-through mode, the output is high in every base-clock high phase from the first edge on. A disable or an idle bus_busy takes effect on the next edge, so a started high half ends on its normal terminal count. A disable in pass-through mode shows low from the second high phase onward. The bench samples once per base cycle, 1 ns after the rising edge, while the base clock is still high. The expected level for each cycle is queued at the moment the stimulus is applied, so each comparison lines up with the edge count given above.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Control word bit positions; the select byte starts at bit 0.
  localparam int unsigned EN_POS      = 8;
  localparam int unsigned AUTO_POS    = 9;
  localparam int unsigned DIV1_POS    = 10;
  localparam int unsigned DIV1024_POS = 16;

  typedef struct packed {
    logic en;
    logic auto_stop;
    logic div1;
    logic div1024;
  } ctl_flags_t;
endpackage

// File: rtl/sdclk_ctl_reg.sv
module sdclk_ctl_reg
  import sdclk_pkg::*;
#(
  parameter int unsigned CTL_W       = 32,
  parameter int unsigned SEL_W       = 8,
  parameter bit          EXT_DIV1024 = 1'b1,
  localparam int unsigned HP_W       = SEL_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic            bus_busy,
  output logic            run,
  output logic            cfg_byp,
  output logic [HP_W-1:0] cfg_hp_m1
);
  ctl_flags_t       flags_q, flags_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic             big_div;

  always_comb begin
    flags_n = flags_q;
    sel_n   = sel_q;
    if (wr) begin
      flags_n.en        = wdata[EN_POS];
      flags_n.auto_stop = wdata[AUTO_POS];
      flags_n.div1      = wdata[DIV1_POS];
      flags_n.div1024   = wdata[DIV1024_POS];
      sel_n             = wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sel_q   <= '0;
    end else begin
      flags_q <= flags_n;
      sel_q   <= sel_n;
    end
  end

  generate
    if (EXT_DIV1024) begin : g_ext
      assign big_div = flags_q.div1024;
    end else begin : g_base
      assign big_div = 1'b0;
    end
  endgenerate

  // Priority: pass-through, then /1024, then highest select bit, else /2.
  always_comb begin
    cfg_hp_m1 = '0;
    for (int i = 0; i < int'(SEL_W); i++) begin
      if (sel_q[i]) cfg_hp_m1 = HP_W'((2 ** (i + 1)) - 1);
    end
    if (big_div) cfg_hp_m1 = {HP_W{1'b1}};
    cfg_byp = flags_q.div1;
  end

  assign run = flags_q.en && !(flags_q.auto_stop && !bus_busy);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int unsigned HP_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            cfg_byp,
  input  logic [HP_W-1:0] cfg_hp_m1,
  output logic            div_q,
  output logic            byp_gate,
  output logic            act_byp,
  output logic [HP_W-1:0] act_hp_m1,
  output logic [HP_W-1:0] cnt
);
  logic            div_n, act_byp_n, stopped, cnt_en;
  logic [HP_W-1:0] cnt_n, act_hp_n;

  assign stopped = !run && !div_q && !byp_gate;
  assign cnt_en  = div_q || (run && !act_byp);

  always_comb begin
    div_n     = div_q;
    cnt_n     = '0;
    act_byp_n = act_byp;
    act_hp_n  = act_hp_m1;
    if (cnt_en) begin
      if (cnt == act_hp_m1) begin
        div_n = !div_q;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
    if (stopped) begin
      act_byp_n = cfg_byp;
      act_hp_n  = cfg_hp_m1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= 1'b0;
      cnt       <= '0;
      act_byp   <= 1'b0;
      act_hp_m1 <= '0;
    end else begin
      div_q     <= div_n;
      cnt       <= cnt_n;
      act_byp   <= act_byp_n;
      act_hp_m1 <= act_hp_n;
    end
  end

  // Pass-through gate only changes while the base clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_gate <= 1'b0;
    else        byp_gate <= run && act_byp;
  end
endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int unsigned CTL_W       = 32,
  parameter int unsigned SEL_W       = 8,
  parameter bit          EXT_DIV1024 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             bus_busy,
  output logic             sd_clk
);
  localparam int unsigned HP_W = SEL_W + 1;

  logic [1:0]      rst_sync;
  logic            rst_n_s;
  logic            run, cfg_byp, div_q, byp_gate, act_byp;
  logic [HP_W-1:0] cfg_hp_m1, act_hp_m1, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  sdclk_ctl_reg #(
    .CTL_W(CTL_W), .SEL_W(SEL_W), .EXT_DIV1024(EXT_DIV1024)
  ) u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr(ctl_wr), .wdata(ctl_wdata),
    .bus_busy(bus_busy), .run(run), .cfg_byp(cfg_byp), .cfg_hp_m1(cfg_hp_m1)
  );

  sdclk_div #(.HP_W(HP_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(run), .cfg_byp(cfg_byp),
    .cfg_hp_m1(cfg_hp_m1), .div_q(div_q), .byp_gate(byp_gate),
    .act_byp(act_byp), .act_hp_m1(act_hp_m1), .cnt(cnt)
  );

  assign sd_clk = (clk && byp_gate) || div_q;
endmodule

// File: rtl/sdclk_chk.sv
module sdclk_chk #(
  parameter int unsigned HP_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            div_q,
  input logic            byp_gate,
  input logic            act_byp,
  input logic [HP_W-1:0] act_hp_m1,
  input logic [HP_W-1:0] cnt
);
  p_toggle_at_terminal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> ($past(cnt) == $past(act_hp_m1)));

  p_stopped_stays_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !div_q) |=> !div_q);

  p_cfg_frozen_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q || byp_gate) |=> ($stable(act_hp_m1) && $stable(act_byp)));

  p_bypass_no_divide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_byp |-> !div_q);

  p_gate_needs_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byp_gate |-> act_byp);
endmodule

bind sd_clk_gen sdclk_chk #(.HP_W(HP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .run(run), .div_q(div_q), .byp_gate(byp_gate),
  .act_byp(act_byp), .act_hp_m1(act_hp_m1), .cnt(cnt)
);

// File: tb/sd_clk_gen_tb.sv
`timescale 1ns/100ps
module sd_clk_gen_tb;
  localparam int unsigned CTL_W = 32;
  localparam logic [CTL_W-1:0] EN = 32'h100, AUTO = 32'h200,
                               D1 = 32'h400, D1K = 32'h1_0000;

  typedef struct {
    logic  e_main;
    logic  e_alt;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [CTL_W-1:0] ctl_wdata = '0;
  logic bus_busy = 1'b1;
  logic sd_main, sd_alt;
  item_t q[$];
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sd_clk_gen #(.CTL_W(CTL_W), .SEL_W(8), .EXT_DIV1024(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bus_busy(bus_busy), .sd_clk(sd_main));

  sd_clk_gen #(.CTL_W(CTL_W), .SEL_W(8), .EXT_DIV1024(1'b0)) u_dut_base (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bus_busy(bus_busy), .sd_clk(sd_alt));

  // Monitor: one sample per base cycle, 1 ns after the rising edge.
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      checks += 2;
      if (sd_main !== it.e_main) begin
        fails++;
        $display("FAIL %s main: sd_clk=%b expected %b", it.tag, sd_main, it.e_main);
      end
      if (sd_alt !== it.e_alt) begin
        fails++;
        $display("FAIL %s base variant: sd_clk=%b expected %b", it.tag, sd_alt, it.e_alt);
      end
    end
  end

  // Half period 0 stands for pass-through.
  function automatic logic lvl(int h, int k);
    if (h == 0) return 1'b1;
    return logic'((k / h) % 2);
  endfunction

  task automatic push_div(int hm, int ha, int n, string tag);
    for (int k = 1; k <= n; k++) q.push_back('{lvl(hm, k), lvl(ha, k), tag});
  endtask

  task automatic push_bits(logic [31:0] pat, int n, string tag);
    for (int k = 0; k < n; k++) q.push_back('{pat[k], pat[k], tag});
  endtask

  // Called at posedge+1.5; returns at posedge+1.5 of the capturing edge.
  task automatic wr(logic [CTL_W-1:0] w);
    ctl_wr = 1'b1;
    ctl_wdata = w;
    @(posedge clk);
    #1.5;
    ctl_wr = 1'b0;
  endtask

  task automatic settle();
    wait (q.size() == 0);
    @(posedge clk);
    #1.5;
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1.5;
  endtask

  // Stop, let the new setting load, then enable it.
  task automatic setup(logic [CTL_W-1:0] cfg);
    settle();
    wr(cfg & ~EN);
    edges(1100);
    wr(cfg | EN);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(4);
    // R1: nothing runs before the enable bit is written
    push_div(1 << 30, 1 << 30, 10, "R1");
    settle();

    // R2 R10: default /2
    setup(32'h0);
    push_div(1, 1, 12, "R2 R10");

    // R3: bit 0 gives /4, bit 3 gives /32
    setup(32'h1);
    push_div(2, 2, 16, "R3");
    setup(32'h8);
    push_div(16, 16, 70, "R3 R10");

    // R4 R7: pass-through, then disable: low from the second high phase on
    setup(D1);
    push_bits(32'h0000_007F, 12, "R4 R7");
    edges(6);
    wr(D1);

    // R6: /1 beats /1024 and the select byte
    setup(D1 | D1K | 32'h20);
    push_div(0, 0, 10, "R6");

    // R5 R6: /1024 over bit 3 in the extended variant; ignored in the base one
    setup(D1K | 32'h8);
    push_div(512, 16, 1100, "R5 R6");

    // R6 R3: highest select bit wins: bit 7 over bit 2 gives /512
    setup(32'h84);
    push_div(256, 256, 530, "R6 R3");

    // R7: clearing enable during a high half of /8 lets it finish
    setup(32'h2);
    push_bits(32'h0000_0078, 14, "R7");
    edges(5);
    wr(32'h2);

    // R8: a new ratio written while running is ignored
    setup(32'h1);
    push_div(2, 2, 14, "R8");
    edges(3);
    wr(EN | 32'h80);

    // R9: auto-stop on idle bus, restart on busy
    bus_busy = 1'b1;
    setup(AUTO | 32'h1);
    push_bits(32'h0000_0306, 12, "R9");
    edges(2);
    bus_busy = 1'b0;
    edges(5);
    bus_busy = 1'b1;

    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule